// File: doc/BRIEF.md
# Receive DMA Queue Selector

This block picks, once per received Ethernet frame, which of two host buffer descriptor queues (queue 1 or queue 2) takes the frame's data. A 3-bit mode input sets the rule: queue 1 only, queue 1 by default, a choice by frame size against a small-buffer length, a choice by frame priority, or a header split in which the first bytes of an IP frame go to queue 1 and the rest go to queue 2. A frame processor may force the choice. When the chosen queue has no free buffers, the block can fall back to the other queue.

The receive path holds `frm_valid` high while a frame is in progress and presents the frame's attributes. When the decision can be made, the block registers it and holds it until `eof_accept`. From the cycle after the decision, `start_ok` allows the DMA to begin and `seg_q2` gives the queue for the segment whose byte offset is on `seg_offset`. If no queue can take the frame, the block raises `drop` instead.

Top module: `rxq_selector`

## Requirements
- R1: With `cfg_mode` = 000 every frame goes to queue 1 (`seg_q2` = 0). The processor override and the backup setting have no effect, and if queue 1 has no buffers the frame is dropped even when queue 2 has some.
- R2: With `cfg_mode` = 001 and no override, frames go to queue 1.
- R3: With `cfg_mode` = 010 a frame whose length is at most `cfg_small_len` goes to queue 2 and a longer one goes to queue 1. The length is taken from `fp_len` when `fp_len_valid` is set, otherwise from `rx_bytes` once `rx_eof` is set.
- R4: With `cfg_mode` = 010 no decision is made (`start_ok` and `drop` stay 0) until `rx_bytes` exceeds `cfg_small_len`, `rx_eof` is set, or `fp_len_valid` is set, whichever comes first.
- R5: With `cfg_mode` = 011 frames with `frm_hi_pri` = 1 go to queue 2 and the others go to queue 1.
- R6: With `cfg_mode` = 100, for an IP frame a segment with `seg_offset` below the latched `hdr_cut` goes to queue 1 and any later segment goes to queue 2. A non-IP frame goes wholly to queue 2. A split frame is dropped unless both queues have buffers.
- R7: In any mode other than 000, `fp_ovr_valid` replaces the computed choice with `fp_ovr_q2` (1 = queue 2) and cancels the split.
- R8: When `cfg_backup_en` = 1, the mode is not 000 and the chosen queue has no buffers, the frame goes to the other queue if that queue has buffers.
- R9: When no allowed queue has buffers, `drop` is 1 and `start_ok` and `seg_q2` are 0 for that frame.
- R10: Mode codes 101, 110 and 111 behave exactly as 000.
- R11: The decision is made in the first cycle in which `frm_valid` is high and the mode's start condition holds. It appears on the outputs in the next cycle and does not change until the cycle after `eof_accept` is sampled high, whatever the other inputs do.
- R12: During reset and while no decision is held, `start_ok`, `drop` and `seg_q2` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Queue selection mode |
| cfg_backup_en | input | 1 | Allow fallback to the other queue |
| cfg_small_len | input | LEN_W | Small-buffer length threshold in bytes |
| frm_valid | input | 1 | A frame is in progress and its attributes are valid |
| rx_bytes | input | LEN_W | Bytes of the current frame received so far |
| rx_eof | input | 1 | The whole current frame has arrived |
| frm_hi_pri | input | 1 | Frame is high priority |
| frm_is_ip | input | 1 | Frame is an IP frame |
| hdr_cut | input | LEN_W | Header cutoff byte offset from the frame processor |
| fp_len_valid | input | 1 | Frame processor supplies the frame length |
| fp_len | input | LEN_W | Frame length from the frame processor |
| fp_ovr_valid | input | 1 | Frame processor forces the queue |
| fp_ovr_q2 | input | 1 | Forced queue, 1 = queue 2 |
| q1_avail | input | 1 | Queue 1 has free buffers |
| q2_avail | input | 1 | Queue 2 has free buffers |
| eof_accept | input | 1 | End of frame accepted; releases the decision |
| seg_offset | input | LEN_W | Byte offset of the segment being transferred |
| start_ok | output | 1 | DMA of the current frame may proceed |
| seg_q2 | output | 1 | Queue for the current segment, 1 = queue 2 |
| drop | output | 1 | Current frame cannot be placed and is dropped |

## Verification
The bench targets the size boundary: a frame exactly at the threshold must take queue 2, and a design using the wrong comparison would put it in queue 1. It checks that a size-mode frame waits while the byte count is still at or below the threshold, since an eager design would start early with a wrong guess. In mode 000 it checks that the override and backup are ignored, and it feeds the reserved codes, which a design with partial decoding would treat as live modes. It also changes the mode and attributes in the middle of a frame to catch a design whose decision does not stay latched, and it tests the header-split cutoff at its exact offset.

// File: rtl/rxq_pkg.sv
// Package: shared mode encoding and the per-frame decision record.
// Assumes codes above the split mode are reserved and map to queue-1-only.
package rxq_pkg;

    typedef enum logic [2:0] {
        M_Q1ONLY = 3'd0,
        M_Q1DEF  = 3'd1,
        M_SIZE   = 3'd2,
        M_PRIO   = 3'd3,
        M_SPLIT  = 3'd4
    } rxq_mode_e;

    typedef struct packed {
        logic drop;   // no queue can take the frame
        logic q2;     // whole-frame queue when not split
        logic split;  // header split active
    } rxq_pick_t;

    // Fold reserved codes onto the queue-1-only mode.
    function automatic rxq_mode_e rxq_norm(input logic [2:0] code);
        return (code > 3'd4) ? M_Q1ONLY : rxq_mode_e'(code);
    endfunction

endpackage

// File: rtl/rxq_ready.sv
// Module: start condition. Size mode waits for proof of length; others start at once.
// Assumes rx_bytes grows monotonically within a frame.
module rxq_ready
    import rxq_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  rxq_mode_e        mode,
    input  logic [LEN_W-1:0] rx_bytes,
    input  logic [LEN_W-1:0] small_len,
    input  logic             rx_eof,
    input  logic             fp_len_valid,
    output logic             ready
);

    // Size mode needs the length settled or shown to exceed the threshold.
    always_comb begin
        if (mode == M_SIZE)
            ready = rx_eof || fp_len_valid || (rx_bytes > small_len);
        else
            ready = 1'b1;
    end

endmodule

// File: rtl/rxq_pick.sv
// Module: combinational queue choice for a frame, including override,
// backup fallback and drop. Assumes the avail flags are current.
module rxq_pick
    import rxq_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  rxq_mode_e        mode,
    input  logic             backup_en,
    input  logic [LEN_W-1:0] small_len,
    input  logic [LEN_W-1:0] rx_bytes,
    input  logic             rx_eof,
    input  logic             fp_len_valid,
    input  logic [LEN_W-1:0] fp_len,
    input  logic             hi_pri,
    input  logic             is_ip,
    input  logic             ovr_valid,
    input  logic             ovr_q2,
    input  logic [1:0]       avail,      // [0] queue 1, [1] queue 2
    output rxq_pick_t        pick
);

    logic             want;
    logic             split;
    logic [LEN_W-1:0] len;
    logic             len_known;

    // Best known frame length: processor value first, then the final count.
    always_comb begin
        len_known = fp_len_valid || rx_eof;
        len       = fp_len_valid ? fp_len : rx_bytes;
    end

    // Preferred queue from mode or override.
    always_comb begin
        want  = 1'b0;
        split = 1'b0;
        if (mode != M_Q1ONLY && ovr_valid) begin
            want = ovr_q2;
        end else begin
            unique case (mode)
                M_SIZE:  want = len_known && (len <= small_len);
                M_PRIO:  want = hi_pri;
                M_SPLIT: begin
                    split = is_ip;
                    want  = !is_ip;
                end
                default: want = 1'b0;
            endcase
        end
    end

    // Apply buffer availability, fallback and drop.
    always_comb begin
        pick = '0;
        if (split) begin
            pick.split = 1'b1;
            pick.drop  = !(avail[0] && avail[1]);
        end else if (avail[want]) begin
            pick.q2 = want;
        end else if (backup_en && mode != M_Q1ONLY && avail[!want]) begin
            pick.q2 = !want;
        end else begin
            pick.drop = 1'b1;
        end
    end

endmodule

// File: rtl/rxq_latch.sv
// Module: holds one frame's decision from the start condition until
// end-of-frame acceptance, and maps segment offsets to a queue.
module rxq_latch
    import rxq_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_valid,
    input  logic             ready,
    input  logic             eof_accept,
    input  rxq_pick_t        pick,
    input  logic [LEN_W-1:0] hdr_cut,
    input  logic [LEN_W-1:0] seg_offset,
    output logic             start_ok,
    output logic             seg_q2,
    output logic             drop
);

    logic             held;
    rxq_pick_t        pk_r;
    logic [LEN_W-1:0] cut_r;

    // Capture the decision once per frame; release on end-of-frame accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= 1'b0;
            pk_r  <= '0;
            cut_r <= '0;
        end else if (held) begin
            if (eof_accept)
                held <= 1'b0;
        end else if (frm_valid && ready) begin
            held  <= 1'b1;
            pk_r  <= pick;
            cut_r <= hdr_cut;
        end
    end

    // Drive permission, drop and the per-segment queue from held state.
    always_comb begin
        start_ok = held && !pk_r.drop;
        drop     = held && pk_r.drop;
        seg_q2   = start_ok && (pk_r.split ? (seg_offset >= cut_r) : pk_r.q2);
    end

endmodule

// File: rtl/rxq_selector.sv
// Module: top of the receive queue selector. Normalises the mode, finds
// the start condition, computes the choice and latches it per frame.
module rxq_selector
    import rxq_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_backup_en,
    input  logic [LEN_W-1:0] cfg_small_len,
    input  logic             frm_valid,
    input  logic [LEN_W-1:0] rx_bytes,
    input  logic             rx_eof,
    input  logic             frm_hi_pri,
    input  logic             frm_is_ip,
    input  logic [LEN_W-1:0] hdr_cut,
    input  logic             fp_len_valid,
    input  logic [LEN_W-1:0] fp_len,
    input  logic             fp_ovr_valid,
    input  logic             fp_ovr_q2,
    input  logic             q1_avail,
    input  logic             q2_avail,
    input  logic             eof_accept,
    input  logic [LEN_W-1:0] seg_offset,
    output logic             start_ok,
    output logic             seg_q2,
    output logic             drop
);

    rxq_mode_e mode;
    logic      ready;
    rxq_pick_t pick;

    // Reserved codes collapse onto queue-1-only.
    always_comb mode = rxq_norm(cfg_mode);

    rxq_ready #(.LEN_W(LEN_W)) u_ready (
        .mode         (mode),
        .rx_bytes     (rx_bytes),
        .small_len    (cfg_small_len),
        .rx_eof       (rx_eof),
        .fp_len_valid (fp_len_valid),
        .ready        (ready)
    );

    rxq_pick #(.LEN_W(LEN_W)) u_pick (
        .mode         (mode),
        .backup_en    (cfg_backup_en),
        .small_len    (cfg_small_len),
        .rx_bytes     (rx_bytes),
        .rx_eof       (rx_eof),
        .fp_len_valid (fp_len_valid),
        .fp_len       (fp_len),
        .hi_pri       (frm_hi_pri),
        .is_ip        (frm_is_ip),
        .ovr_valid    (fp_ovr_valid),
        .ovr_q2       (fp_ovr_q2),
        .avail        ({q2_avail, q1_avail}),
        .pick         (pick)
    );

    rxq_latch #(.LEN_W(LEN_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_valid  (frm_valid),
        .ready      (ready),
        .eof_accept (eof_accept),
        .pick       (pick),
        .hdr_cut    (hdr_cut),
        .seg_offset (seg_offset),
        .start_ok   (start_ok),
        .seg_q2     (seg_q2),
        .drop       (drop)
    );

endmodule

// File: rtl/rxq_checker.sv
// Module: temporal checks on the selector's ports, bound to every instance.
module rxq_checker #(
    parameter int LEN_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cfg_mode,
    input logic [LEN_W-1:0] cfg_small_len,
    input logic [LEN_W-1:0] rx_bytes,
    input logic             rx_eof,
    input logic             fp_len_valid,
    input logic             fp_ovr_valid,
    input logic             frm_is_ip,
    input logic [LEN_W-1:0] hdr_cut,
    input logic [LEN_W-1:0] seg_offset,
    input logic             eof_accept,
    input logic             start_ok,
    input logic             seg_q2,
    input logic             drop
);

    AST_NO_DUAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_ok && drop));  // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_ok || drop) && !eof_accept) |=> ($stable(start_ok) && $stable(drop)));  // R11

    AST_EOF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_ok || drop) && eof_accept) |=> (!start_ok && !drop));  // R11

    AST_Q1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_ok) && ($past(cfg_mode) == 3'b000 || $past(cfg_mode) > 3'b100)) |-> !seg_q2);  // R1

    AST_SIZE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ok && !drop && cfg_mode == 3'b010 && !rx_eof && !fp_len_valid
         && rx_bytes <= cfg_small_len) |=> (!start_ok && !drop));  // R4

    AST_SPLIT_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_ok) && $past(cfg_mode) == 3'b100 && $past(frm_is_ip)
         && !$past(fp_ovr_valid) && seg_offset < $past(hdr_cut)) |-> !seg_q2);  // R6

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !start_ok |-> !seg_q2);  // R12

endmodule

bind rxq_selector rxq_checker #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_rxq_selector.sv
module sim_rxq_selector;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 14;

    logic          clk = 0, rst_n = 0;
    logic [2:0]    cfg_mode = 0;
    logic          cfg_backup_en = 0;
    logic [LW-1:0] cfg_small_len = 100;
    logic          frm_valid = 0, rx_eof = 0, frm_hi_pri = 0, frm_is_ip = 0;
    logic [LW-1:0] rx_bytes = 0, hdr_cut = 0, fp_len = 0, seg_offset = 0;
    logic          fp_len_valid = 0, fp_ovr_valid = 0, fp_ovr_q2 = 0;
    logic          q1_avail = 1, q2_avail = 1, eof_accept = 0;
    logic          start_ok, seg_q2, drop;

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_req = "R12";

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_selector #(.LEN_W(LW)) u0 (.*);

    // Behavioural reference state.
    bit m_held = 0, m_drop = 0, m_q2 = 0, m_split = 0;
    int m_cut = 0;

    always @(posedge clk) begin
        int md, want, len;
        bit rdy, sp, av1, av2;
        if (!rst_n) begin
            m_held = 0; m_drop = 0; m_q2 = 0; m_split = 0; m_cut = 0;
        end else if (m_held) begin
            if (eof_accept) m_held = 0;
        end else begin
            md = (cfg_mode > 4) ? 0 : int'(cfg_mode);
            rdy = (md != 2) || rx_eof || fp_len_valid || (rx_bytes > cfg_small_len);
            if (frm_valid && rdy) begin
                want = 0; sp = 0;
                if (md != 0 && fp_ovr_valid) want = int'(fp_ovr_q2);
                else if (md == 2) begin
                    len = fp_len_valid ? int'(fp_len) : int'(rx_bytes);
                    want = ((fp_len_valid || rx_eof) && len <= int'(cfg_small_len)) ? 1 : 0;
                end else if (md == 3) want = int'(frm_hi_pri);
                else if (md == 4) begin sp = frm_is_ip; want = frm_is_ip ? 0 : 1; end
                av1 = q1_avail; av2 = q2_avail;
                m_held = 1; m_split = sp; m_cut = int'(hdr_cut); m_drop = 0; m_q2 = 0;
                if (sp) m_drop = !(av1 && av2);
                else if ((want == 1) ? av2 : av1) m_q2 = (want == 1);
                else if (cfg_backup_en && md != 0 && ((want == 1) ? av1 : av2)) m_q2 = (want != 1);
                else m_drop = 1;
            end
        end
    end

    // Compare against the reference on every falling edge.
    always @(negedge clk) begin
        bit es, ed, eq;
        es = m_held && !m_drop;
        ed = m_held && m_drop;
        eq = es && (m_split ? (int'(seg_offset) >= m_cut) : m_q2);
        checks++;
        if (start_ok !== es || drop !== ed || seg_q2 !== eq) begin
            fails++;
            $display("FAIL %s model: start/drop/q2 got %b%b%b exp %b%b%b",
                     cur_req, start_ok, drop, seg_q2, es, ed, eq);
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic expect_out(string req, bit s, bit d, bit q);
        checks++;
        if (start_ok !== s || drop !== d || seg_q2 !== q) begin
            fails++;
            $display("FAIL %s: start/drop/q2 got %b%b%b exp %b%b%b",
                     req, start_ok, drop, seg_q2, s, d, q);
        end
    endtask

    task automatic end_frame();
        eof_accept = 1; frm_valid = 0; step(1);
        eof_accept = 0;
        expect_out("R11 release", 0, 0, 0);
        rx_eof = 0; rx_bytes = 0; fp_len_valid = 0; fp_ovr_valid = 0; fp_ovr_q2 = 0;
        frm_hi_pri = 0; frm_is_ip = 0; seg_offset = 0; q1_avail = 1; q2_avail = 1;
        cfg_backup_en = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, got timeout exp completion");
            summary();
        end
    end

    initial begin
        step(3);
        expect_out("R12 reset", 0, 0, 0);
        rst_n = 1; step(1);
        expect_out("R12 idle", 0, 0, 0);

        cur_req = "R1"; cfg_mode = 3'b000; fp_ovr_valid = 1; fp_ovr_q2 = 1; frm_valid = 1;
        step(1); expect_out("R1 R7 override ignored", 1, 0, 0); end_frame();

        q1_avail = 0; cfg_backup_en = 1; frm_valid = 1;
        step(1); expect_out("R1 no backup", 0, 1, 0); end_frame();

        cur_req = "R10"; cfg_mode = 3'b111; frm_hi_pri = 1; frm_valid = 1;
        step(1); expect_out("R10 reserved", 1, 0, 0); end_frame();
        cfg_mode = 3'b101; q1_avail = 0; cfg_backup_en = 1; frm_valid = 1;
        step(1); expect_out("R10 reserved drop", 0, 1, 0); end_frame();

        cur_req = "R2"; cfg_mode = 3'b001; frm_valid = 1;
        step(1); expect_out("R2 default q1", 1, 0, 0); end_frame();
        cur_req = "R7"; fp_ovr_valid = 1; fp_ovr_q2 = 1; frm_valid = 1;
        step(1); expect_out("R7 override q2", 1, 0, 1); end_frame();

        cur_req = "R4"; cfg_mode = 3'b010; rx_bytes = 100; frm_valid = 1;
        step(2); expect_out("R4 wait at threshold", 0, 0, 0);
        rx_eof = 1; step(1); expect_out("R3 small at boundary", 1, 0, 1); end_frame();
        rx_bytes = 101; frm_valid = 1;
        step(1); expect_out("R4 R3 over threshold", 1, 0, 0); end_frame();
        rx_bytes = 10; fp_len_valid = 1; fp_len = 100; frm_valid = 1;
        step(1); expect_out("R4 R3 processor length", 1, 0, 1); end_frame();
        rx_bytes = 10; fp_len_valid = 1; fp_len = 101; frm_valid = 1;
        step(1); expect_out("R3 processor long", 1, 0, 0); end_frame();

        cur_req = "R5"; cfg_mode = 3'b011; frm_hi_pri = 1; frm_valid = 1;
        step(1); expect_out("R5 high", 1, 0, 1); end_frame();
        frm_valid = 1; step(1); expect_out("R5 standard", 1, 0, 0); end_frame();

        cur_req = "R6"; cfg_mode = 3'b100; frm_is_ip = 1; hdr_cut = 54; frm_valid = 1;
        step(1); expect_out("R6 header seg", 1, 0, 0);
        seg_offset = 53; #1 expect_out("R6 last header byte", 1, 0, 0);
        seg_offset = 54; #1 expect_out("R6 payload at cut", 1, 0, 1);
        hdr_cut = 0; #1 expect_out("R11 cut latched", 1, 0, 1); end_frame();
        frm_valid = 1; step(1); expect_out("R6 non-IP", 1, 0, 1); end_frame();
        frm_is_ip = 1; q2_avail = 0; cfg_backup_en = 1; frm_valid = 1;
        step(1); expect_out("R6 split needs both", 0, 1, 0); end_frame();

        cur_req = "R8"; cfg_mode = 3'b001; q1_avail = 0; cfg_backup_en = 1; frm_valid = 1;
        step(1); expect_out("R8 backup to q2", 1, 0, 1); end_frame();
        cfg_mode = 3'b011; frm_hi_pri = 1; q2_avail = 0; cfg_backup_en = 1; frm_valid = 1;
        step(1); expect_out("R8 backup to q1", 1, 0, 0); end_frame();
        cur_req = "R9"; cfg_mode = 3'b001; q1_avail = 0; frm_valid = 1;
        step(1); expect_out("R9 no backup drop", 0, 1, 0); end_frame();
        q1_avail = 0; q2_avail = 0; cfg_backup_en = 1; frm_valid = 1;
        step(1); expect_out("R9 both empty", 0, 1, 0); end_frame();

        cur_req = "R11"; cfg_mode = 3'b011; frm_hi_pri = 1; frm_valid = 1;
        step(1); expect_out("R11 decided", 1, 0, 1);
        frm_hi_pri = 0; cfg_mode = 3'b000; q2_avail = 0; step(3);
        expect_out("R11 held", 1, 0, 1); end_frame();

        step(2);
        done = 1;
        summary();
    end
endmodule